// File: doc/BRIEF.md
# Converter Output Mute Sequencer

This block sequences the output side of a sample-rate converter through power-down, acquisition and normal operation. An active-low power-down input passes through a synchronizer. While it is low, the block sits in a power-down state, holds the output sample word at zero and gives a one-cycle pulse that asks the digital filter to initialize. Releasing power-down does not let data through at once. The block first enters a detection phase and waits there until three status indications are all true: input clock present, loop locked and rate detected. Only then does it enter normal operation.

In every state except normal operation, each strobed sample word leaves as zero and an active-high unlock flag is raised. The detection phase has a bounded wait, given as a cycle count. When that count runs out without all three indications, the phase starts over and another filter-initialize pulse is issued. Losing any indication during normal operation sends the block back to detection. The output word changes only on sample-strobe edges, so a word is never cut off partway. The one exception is power-down, which clears the output word at once.

Top module: `cnv_mute_seq`

## Requirements
- R1: During and after reset, before power-down is released: unlock=1, smp_out=0, smp_out_stb=0 and filt_init=0.
- R2: One cycle after the power-down state is entered, smp_out reads 0 and stays 0 whatever is strobed. filt_init is high for exactly one cycle, the first cycle of the power-down state.
- R3: Releasing power-down moves the block into the detection phase. It never moves from power-down straight into normal operation.
- R4: In the detection phase, every strobed word is output as 0. Normal operation begins on the edge after clk_present, pll_lock and rate_found are all 1. Any two of the three are not enough.
- R5: unlock is 0 exactly while the block is in normal operation, including the first cycle of normal operation.
- R6: Outside power-down, smp_out changes only on an edge where smp_stb=1. It loads smp_in in normal operation and 0 otherwise, and holds its value between strobes. smp_out_stb is smp_stb delayed by one cycle.
- R7: If clk_present, pll_lock or rate_found goes to 0 during normal operation, the block returns to detection on the next edge and unlock becomes 1.
- R8: With no lock, filt_init pulses TIMEOUT_CYC cycles after detection is entered, and again every TIMEOUT_CYC cycles after that. The block stays muted throughout.
- R9: After a second power-down and release, the same detection phase comes again before data flows: unlock stays 1 for the three edges after release.
- R10: pwr_dn_n passes through a SYNC_STAGES-stage synchronizer. With 2 stages, a change on it takes effect on the third clock edge. A synchronized power-down overrides every other transition, including normal operation with all indications true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Power-down request, active low, asynchronous |
| clk_present | input | 1 | Input clock present indication |
| pll_lock | input | 1 | Loop lock indication |
| rate_found | input | 1 | Sample-rate detected indication |
| smp_stb | input | 1 | Input sample word strobe |
| smp_in | input | SMP_W | Input sample word |
| smp_out | output | SMP_W | Gated output sample word |
| smp_out_stb | output | 1 | Output sample strobe, one cycle after smp_stb |
| unlock | output | 1 | High in every state except normal operation |
| filt_init | output | 1 | One-cycle filter initialize request |

## Verification
The bench builds the block with SMP_W=8, SYNC_STAGES=2 and TIMEOUT_CYC=20. A detection timeout of twenty cycles puts two successive restart pulses, and their exact cycle positions, within a few dozen cycles of release. The real default would need millions of cycles. The two-stage synchronizer gives a fixed three-edge latency, which the bench checks edge by edge on entry to power-down and on release. The narrow word allows distinct non-zero patterns, so a word that was passed can be told from one that was muted or one that was held.

// File: rtl/cms_pkg.sv
package cms_pkg;
   typedef enum logic [1:0] {
      ST_PDOWN  = 2'd0,
      ST_DETECT = 2'd1,
      ST_RUN    = 2'd2
   } seq_state_e;
endpackage

// File: rtl/cms_sync.sv
module cms_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cms_timer.sv
module cms_timer #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   output logic expire
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   logic [CW-1:0] cnt_q;

   assign expire = run_en && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run_en || expire) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/cms_fsm.sv
module cms_fsm
   import cms_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_on,
   input  logic       clk_ok,
   input  logic       lock_ok,
   input  logic       rate_ok,
   input  logic       expire,
   output seq_state_e st_q,
   output logic       init_q
);
   seq_state_e st_d;
   logic       all_ok;
   logic       init_d;

   assign all_ok = clk_ok && lock_ok && rate_ok;

   always_comb begin
      st_d = st_q;
      if (!pwr_on) begin
         st_d = ST_PDOWN;
      end else begin
         unique case (st_q)
            ST_PDOWN:  st_d = ST_DETECT;
            ST_DETECT: if (all_ok) st_d = ST_RUN;
            ST_RUN:    if (!all_ok) st_d = ST_DETECT;
            default:   st_d = ST_PDOWN;
         endcase
      end
   end

   assign init_d = ((st_d == ST_PDOWN) && (st_q != ST_PDOWN)) ||
                   (pwr_on && (st_q == ST_DETECT) && !all_ok && expire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_PDOWN;
         init_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         init_q <= init_d;
      end
   end
endmodule

// File: rtl/cms_gate.sv
module cms_gate
   import cms_pkg::*;
#(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  seq_state_e   st,
   input  logic         stb,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         dstb
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         dstb <= 1'b0;
      end else begin
         dstb <= stb;
         if (st == ST_PDOWN) dout <= '0;
         else if (stb)       dout <= (st == ST_RUN) ? din : '0;
      end
   end
endmodule

// File: rtl/cnv_mute_seq.sv
module cnv_mute_seq
   import cms_pkg::*;
#(
   parameter int SMP_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 5_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_dn_n,
   input  logic             clk_present,
   input  logic             pll_lock,
   input  logic             rate_found,
   input  logic             smp_stb,
   input  logic [SMP_W-1:0] smp_in,
   output logic [SMP_W-1:0] smp_out,
   output logic             smp_out_stb,
   output logic             unlock,
   output logic             filt_init
);
   if (SMP_W < 1) begin : g_bad_width
      $error("cnv_mute_seq: SMP_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cnv_mute_seq: SYNC_STAGES must be at least 2");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("cnv_mute_seq: TIMEOUT_CYC must be at least 2");
   end

   logic       pwr_on_s;
   logic       expire;
   seq_state_e st_q;

   cms_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pwr_dn_n),
      .q     (pwr_on_s)
   );

   cms_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_en (st_q == ST_DETECT),
      .expire (expire)
   );

   cms_fsm i_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_on  (pwr_on_s),
      .clk_ok  (clk_present),
      .lock_ok (pll_lock),
      .rate_ok (rate_found),
      .expire  (expire),
      .st_q    (st_q),
      .init_q  (filt_init)
   );

   cms_gate #(.W(SMP_W)) i_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .st    (st_q),
      .stb   (smp_stb),
      .din   (smp_in),
      .dout  (smp_out),
      .dstb  (smp_out_stb)
   );

   assign unlock = (st_q != ST_RUN);
endmodule

// File: rtl/cms_chk.sv
module cms_chk
   import cms_pkg::*;
#(
   parameter int SMP_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input seq_state_e       st,
   input logic             pwr_on,
   input logic             clk_present,
   input logic             pll_lock,
   input logic             rate_found,
   input logic             smp_stb,
   input logic [SMP_W-1:0] smp_out,
   input logic             filt_init
);
   // R2: output cleared while powered down
   p_pdown_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PDOWN) |=> (smp_out == '0));

   // R2: filter init is a single-cycle pulse
   p_init_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      filt_init |=> !filt_init);

   // R3: normal operation is never entered from power-down
   p_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN) |-> ($past(st) != ST_PDOWN));

   // R4: entry to normal operation needs all three indications
   p_run_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_RUN) && ($past(st) != ST_RUN)) |->
      $past(clk_present && pll_lock && rate_found));

   // R4: strobed words are zero outside normal operation
   p_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && (st != ST_RUN)) |=> (smp_out == '0));

   // R6: output word holds between strobes
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_stb && (st != ST_PDOWN)) |=> $stable(smp_out));

   // R7: clock loss in normal operation returns to detection
   p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_RUN) && pwr_on && !clk_present) |=> (st == ST_DETECT));

   // R10: synchronized power-down overrides every transition
   p_pd_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |=> (st == ST_PDOWN));
endmodule

bind cnv_mute_seq cms_chk #(.SMP_W(SMP_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .st          (st_q),
   .pwr_on      (pwr_on_s),
   .clk_present (clk_present),
   .pll_lock    (pll_lock),
   .rate_found  (rate_found),
   .smp_stb     (smp_stb),
   .smp_out     (smp_out),
   .filt_init   (filt_init)
);

// File: tb/test_cnv_mute_seq.sv
module test_cnv_mute_seq;
   localparam int W = 8;
   localparam int T = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pwr_dn_n = 1'b0;
   logic         clk_present = 1'b0;
   logic         pll_lock = 1'b0;
   logic         rate_found = 1'b0;
   logic         smp_stb = 1'b0;
   logic [W-1:0] smp_in = '0;
   logic [W-1:0] smp_out;
   logic         smp_out_stb;
   logic         unlock;
   logic         filt_init;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cnv_mute_seq #(.SMP_W(W), .SYNC_STAGES(2), .TIMEOUT_CYC(T)) i_cnv_mute_seq (
      .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .clk_present(clk_present),
      .pll_lock(pll_lock), .rate_found(rate_found), .smp_stb(smp_stb),
      .smp_in(smp_in), .smp_out(smp_out), .smp_out_stb(smp_out_stb),
      .unlock(unlock), .filt_init(filt_init)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic strobe(input logic [W-1:0] v);
      smp_stb = 1'b1;
      smp_in  = v;
      step();
      smp_stb = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      chk("R1 unlock", unlock, 1);
      chk("R1 smp_out", smp_out, 0);
      chk("R1 smp_out_stb", smp_out_stb, 0);
      chk("R1 filt_init", filt_init, 0);
      strobe(8'h5A);
      chk("R2 zero in power-down", smp_out, 0);
      chk("R6 strobe delayed", smp_out_stb, 1);
      step();
      chk("R6 strobe single", smp_out_stb, 0);
   endtask

   task automatic t_release_timeout();
      pwr_dn_n = 1'b1;
      for (int e = 1; e <= 3 + 2 * T; e++) begin
         step();
         chk("R8 restart pulse timing", filt_init, (e == 3 + T || e == 3 + 2 * T) ? 1 : 0);
         chk("R3 unlock during detection", unlock, 1);
      end
      strobe(8'hC3);
      chk("R4 muted in detection", smp_out, 0);
   endtask

   task automatic t_lock();
      clk_present = 1'b1;
      pll_lock    = 1'b1;
      step();
      chk("R4 two of three not enough", unlock, 1);
      rate_found = 1'b1;
      step();
      chk("R5 unlock low in normal", unlock, 0);
      strobe(8'hA5);
      chk("R6 word passed", smp_out, 8'hA5);
      smp_in = 8'h11;
      step();
      chk("R6 word held without strobe", smp_out, 8'hA5);
   endtask

   task automatic t_loss();
      clk_present = 1'b0;
      step();
      chk("R7 unlock on clock loss", unlock, 1);
      chk("R6 held until next strobe", smp_out, 8'hA5);
      strobe(8'h3C);
      chk("R7 muted after clock loss", smp_out, 0);
      clk_present = 1'b1;
      step();
      chk("R5 back in normal", unlock, 0);
      strobe(8'h77);
      chk("R6 word passed again", smp_out, 8'h77);
   endtask

   task automatic t_pdown();
      pwr_dn_n = 1'b0;
      step();
      chk("R10 edge1 still normal", unlock, 0);
      step();
      chk("R10 edge2 still normal", unlock, 0);
      chk("R10 edge2 no init", filt_init, 0);
      step();
      chk("R10 edge3 power-down over lock", unlock, 1);
      chk("R2 init pulse", filt_init, 1);
      step();
      chk("R2 output cleared", smp_out, 0);
      chk("R2 init single cycle", filt_init, 0);
      strobe(8'h99);
      chk("R2 strobe ignored in power-down", smp_out, 0);
   endtask

   task automatic t_rerelease();
      pwr_dn_n = 1'b1;
      for (int e = 1; e <= 4; e++) begin
         step();
         chk("R9 detection repeats", unlock, (e == 4) ? 0 : 1);
      end
      strobe(8'h42);
      chk("R9 data after re-release", smp_out, 8'h42);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_release_timeout();
      t_lock();
      t_loss();
      t_pdown();
      t_rerelease();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule